// File: doc/BRIEF.md
# Word-Serial Address-Event Burst Receiver

This block takes a word-serial stream of spike addresses and hands each spike to a two-dimensional array of neuron inputs. Spikes come in bursts. A burst opens with a chip identifier, then gives one row address, then lists any number of column addresses. Each column address names one neuron in that row that fired. The block keeps track of where it is inside the burst. For every column word it strobes one active-low row line and one active-low column line into the array. It waits until the array confirms that the spike arrived, and only then acknowledges the word to the sender.

The sender raises a level request for the whole burst, marks each later word with an active-low word request, and sees every accepted word as one toggle of the acknowledge line. All handshake inputs are brought into the local clock domain through synchronisers. Only bursts with chip identifier zero are delivered to the local array. Bursts from other chips are acknowledged word by word but deliver nothing. Each pixel holds four neurons, picked by the least significant bits of the row and column addresses. The block reports which of the four kinds each delivered event targeted.

Top module: `aer_burst_rx`

## Requirements
- R1: While reset is held and directly after it, `aer_ack` is 0, all `row_sel_n` and `col_sel_n` lines are 1, and `evt_valid` and `range_err` are 0.
- R2: A rise of `burst_req` opens a burst. The value on `aer_addr` at that time is taken as the chip identifier, and the block answers with exactly one toggle of `aer_ack`.
- R3: Every later word is flagged by `word_req_n` going low and gets exactly one toggle of `aer_ack`. The next word is accepted only after `word_req_n` has returned high, however long it is held low.
- R4: The first flagged word of a burst is the row address. It drives no select line and produces no event.
- R5: In a burst from chip 0 with a valid row, a column word with address below COLS pulls exactly one line `row_sel_n[row]` and exactly one line `col_sel_n[col]` low together. Both stay low until the array answers.
- R6: A delivered column word is acknowledged only after `dlv_ack_n` has been seen low and then high again. All select lines are back at 1 whenever `aer_ack` toggles.
- R7: Each delivery pulses `evt_valid` for one cycle, with `evt_row` and `evt_col` giving the address. `evt_kind` = {row LSB, column LSB} encodes the neuron kind: 0 even/on, 1 even/off, 2 odd/on, 3 odd/off.
- R8: In a burst whose chip identifier is not zero, every word is acknowledged, no select line moves, and no event or error is reported.
- R9: In a burst from chip 0, a column word at or above COLS is acknowledged and dropped with a one-cycle `range_err`, and later columns of the same burst are still delivered. A row word at or above ROWS raises `range_err` and causes every column of that burst to be dropped.
- R10: A fall of `burst_req` ends the burst. The next burst starts again with a chip word and then a row word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| aer_addr | input | ADDR_W | Address word from the sender |
| burst_req | input | 1 | Burst request, high for the whole burst |
| word_req_n | input | 1 | Word request, active low, one pulse per word after the chip word |
| aer_ack | output | 1 | Word acknowledge, one toggle per accepted word |
| row_sel_n | output | ROWS | Active-low row strobes to the array |
| col_sel_n | output | COLS | Active-low column strobes to the array |
| dlv_ack_n | input | 1 | Active-low delivery confirmation from the array |
| evt_valid | output | 1 | One-cycle pulse per delivered event |
| evt_kind | output | 2 | Neuron kind of the event, {row LSB, column LSB} |
| evt_row | output | ROW_W | Row address of the event |
| evt_col | output | COL_W | Column address of the event |
| range_err | output | 1 | One-cycle pulse when an out-of-range word is dropped |

## Verification
The hardest cases to reach from the ports are the ones where a word ends in something other than a delivery: a foreign chip identifier, a column past the array edge, or an invalid row that silences the rest of its burst. The bench gets to each of them by opening a fresh burst with the matching chip and row words. It then counts acknowledge toggles, select strobes and error pulses across the next column words. The bench also models the array with a delayed confirmation and holds a word request low long after the acknowledge. This shows that a held request is never taken as a second word, and that no acknowledge appears while a select line is still low.

// File: rtl/aer_rx_pkg.sv
`timescale 1ns/1ps
package aer_rx_pkg;

    // Receiver sequencing
    typedef enum logic [2:0] {
        ST_IDLE,      // no burst open
        ST_WAIT_HI,   // word request must return high before next word
        ST_READY,     // ready to take the next word
        ST_DELIVER,   // selects driven, waiting for array confirmation
        ST_RELEASE    // selects dropped, waiting for confirmation release
    } rx_state_e;

    // Neuron kind inside a pixel: {row lsb, column lsb}
    typedef enum logic [1:0] {
        NK_EVEN_ON  = 2'd0,
        NK_EVEN_OFF = 2'd1,
        NK_ODD_ON   = 2'd2,
        NK_ODD_OFF  = 2'd3
    } neuron_kind_e;

    // Outcome for a column word
    typedef struct packed {
        logic deliver;
        logic drop_err;
    } col_verdict_t;

    function automatic neuron_kind_e kind_of(input logic row_lsb, input logic col_lsb);
        return neuron_kind_e'({row_lsb, col_lsb});
    endfunction

    function automatic col_verdict_t judge_col(input logic local_burst,
                                               input logic row_ok,
                                               input logic col_ok);
        col_verdict_t v;
        v.deliver  = local_burst & row_ok & col_ok;
        v.drop_err = local_burst & row_ok & ~col_ok;
        return v;
    endfunction

endpackage

// File: rtl/aer_sync.sv
`timescale 1ns/1ps
module aer_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/aer_select_drv.sv
`timescale 1ns/1ps
module aer_select_drv #(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             drop_sel,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [ROWS-1:0]  row_sel_n,
    output logic [COLS-1:0]  col_sel_n
);
    always_ff @(posedge clk) begin
        if (rst || drop_sel) begin
            row_sel_n <= '1;
            col_sel_n <= '1;
        end else if (fire) begin
            for (int r = 0; r < ROWS; r++)
                if (row == ROW_W'(r)) row_sel_n[r] <= 1'b0;
            for (int c = 0; c < COLS; c++)
                if (col == COL_W'(c)) col_sel_n[c] <= 1'b0;
        end
    end

    AST_SEL_PAIRED: assert property (@(posedge clk) disable iff (rst)
        ($countones(~row_sel_n) == $countones(~col_sel_n)) && ($countones(~row_sel_n) <= 1)); // R5

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(&row_sel_n) && !drop_sel) |=> $stable(row_sel_n) && $stable(col_sel_n)); // R5
endmodule

// File: rtl/aer_burst_fsm.sv
`timescale 1ns/1ps
module aer_burst_fsm
    import aer_rx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ROWS = 16,
    parameter int COLS = 32,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_s,
    input  logic              wreq_n_s,
    input  logic              dack_n_s,
    input  logic [ADDR_W-1:0] addr,
    output logic              ack_q,
    output logic              fire,
    output logic              drop_sel,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_q,
    output logic              evt_valid,
    output logic [1:0]        evt_kind,
    output logic              range_err
);
    localparam logic [ADDR_W-1:0] ROW_LIM = ADDR_W'(ROWS);
    localparam logic [ADDR_W-1:0] COL_LIM = ADDR_W'(COLS);

    rx_state_e    st_q;
    logic         local_q;
    logic         have_row_q;
    logic         row_ok_q;
    logic         row_in;
    logic         col_in;
    col_verdict_t verdict;

    assign row_in  = addr < ROW_LIM;
    assign col_in  = addr < COL_LIM;
    assign verdict = judge_col(local_q, row_ok_q, col_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            ack_q      <= 1'b0;
            local_q    <= 1'b0;
            have_row_q <= 1'b0;
            row_ok_q   <= 1'b0;
            row_q      <= '0;
            col_q      <= '0;
            fire       <= 1'b0;
            drop_sel   <= 1'b0;
            evt_valid  <= 1'b0;
            evt_kind   <= 2'd0;
            range_err  <= 1'b0;
        end else begin
            fire      <= 1'b0;
            drop_sel  <= 1'b0;
            evt_valid <= 1'b0;
            range_err <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (burst_s) begin
                        // chip word: only identifier zero is local
                        local_q    <= (addr == '0);
                        have_row_q <= 1'b0;
                        row_ok_q   <= 1'b0;
                        ack_q      <= ~ack_q;
                        st_q       <= ST_WAIT_HI;
                    end
                end
                ST_WAIT_HI: begin
                    if (!burst_s)      st_q <= ST_IDLE;
                    else if (wreq_n_s) st_q <= ST_READY;
                end
                ST_READY: begin
                    if (!burst_s) begin
                        st_q <= ST_IDLE;
                    end else if (!wreq_n_s) begin
                        if (!have_row_q) begin
                            have_row_q <= 1'b1;
                            row_ok_q   <= row_in;
                            row_q      <= addr[ROW_W-1:0];
                            range_err  <= local_q & ~row_in;
                            ack_q      <= ~ack_q;
                            st_q       <= ST_WAIT_HI;
                        end else if (verdict.deliver) begin
                            col_q     <= addr[COL_W-1:0];
                            fire      <= 1'b1;
                            evt_valid <= 1'b1;
                            evt_kind  <= kind_of(row_q[0], addr[0]);
                            st_q      <= ST_DELIVER;
                        end else begin
                            range_err <= verdict.drop_err;
                            ack_q     <= ~ack_q;
                            st_q      <= ST_WAIT_HI;
                        end
                    end
                end
                ST_DELIVER: begin
                    if (!dack_n_s) begin
                        drop_sel <= 1'b1;
                        st_q     <= ST_RELEASE;
                    end
                end
                ST_RELEASE: begin
                    if (dack_n_s) begin
                        ack_q <= ~ack_q;
                        st_q  <= ST_WAIT_HI;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_ACK_WAITS_DLV: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DELIVER) |=> $stable(ack_q)); // R6

    AST_REMOTE_SILENT: assert property (@(posedge clk) disable iff (rst)
        fire |-> (local_q && row_ok_q && have_row_q)); // R8

    AST_DROP_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
        range_err |-> (!fire && !evt_valid && local_q)); // R9

    AST_WORD_NEEDS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT_HI && !wreq_n_s && burst_s) |=> $stable(ack_q)); // R3
endmodule

// File: rtl/aer_burst_rx.sv
`timescale 1ns/1ps
module aer_burst_rx #(
    parameter int ADDR_W = 8,
    parameter int ROWS = 16,
    parameter int COLS = 32,
    parameter int SYNC_STAGES = 2,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] aer_addr,
    input  logic              burst_req,
    input  logic              word_req_n,
    output logic              aer_ack,
    output logic [ROWS-1:0]   row_sel_n,
    output logic [COLS-1:0]   col_sel_n,
    input  logic              dlv_ack_n,
    output logic              evt_valid,
    output logic [1:0]        evt_kind,
    output logic [ROW_W-1:0]  evt_row,
    output logic [COL_W-1:0]  evt_col,
    output logic              range_err
);
    logic [2:0] hs_raw;
    logic [2:0] hs_sync;
    logic       fire;
    logic       drop_sel;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    assign hs_raw = {burst_req, word_req_n, dlv_ack_n};

    aer_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (hs_raw),
        .q   (hs_sync)
    );

    aer_burst_fsm #(.ADDR_W(ADDR_W), .ROWS(ROWS), .COLS(COLS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .burst_s   (hs_sync[2]),
        .wreq_n_s  (hs_sync[1]),
        .dack_n_s  (hs_sync[0]),
        .addr      (aer_addr),
        .ack_q     (aer_ack),
        .fire      (fire),
        .drop_sel  (drop_sel),
        .row_q     (row_q),
        .col_q     (col_q),
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .range_err (range_err)
    );

    aer_select_drv #(.ROWS(ROWS), .COLS(COLS)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .drop_sel  (drop_sel),
        .row       (row_q),
        .col       (col_q),
        .row_sel_n (row_sel_n),
        .col_sel_n (col_sel_n)
    );

    assign evt_row = row_q;
    assign evt_col = col_q;

    AST_ACK_SEL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !$stable(aer_ack) |-> ((&row_sel_n) && (&col_sel_n))); // R6

    AST_EVT_WITH_SEL: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> (!(&row_sel_n) && !(&col_sel_n))); // R7
endmodule

// File: tb/aer_burst_rx_test.sv
`timescale 1ns/1ps
module aer_burst_rx_test;
    localparam int AW = 8;
    localparam int NR = 16;
    localparam int NC = 32;
    localparam int RW = $clog2(NR);
    localparam int CW = $clog2(NC);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] aer_addr = '0;
    logic          burst_req = 1'b0;
    logic          word_req_n = 1'b1;
    logic          aer_ack;
    logic [NR-1:0] row_sel_n;
    logic [NC-1:0] col_sel_n;
    logic          dlv_ack_n = 1'b1;
    logic          evt_valid;
    logic [1:0]    evt_kind;
    logic [RW-1:0] evt_row;
    logic [CW-1:0] evt_col;
    logic          range_err;

    always #2.5 clk = ~clk;

    aer_burst_rx #(.ADDR_W(AW), .ROWS(NR), .COLS(NC)) uut (
        .clk(clk), .rst(rst), .aer_addr(aer_addr), .burst_req(burst_req),
        .word_req_n(word_req_n), .aer_ack(aer_ack), .row_sel_n(row_sel_n),
        .col_sel_n(col_sel_n), .dlv_ack_n(dlv_ack_n), .evt_valid(evt_valid),
        .evt_kind(evt_kind), .evt_row(evt_row), .evt_col(evt_col),
        .range_err(range_err)
    );

    int checks = 0, errors = 0;
    int ack_cnt = 0, dlv_cnt = 0, evt_cnt = 0, err_cnt = 0;
    int ack_sel_bad = 0, sel_shape_bad = 0;
    int last_row = -1, last_col = -1, last_kind = -1, last_erow = -1, last_ecol = -1;
    logic ack_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // port monitor
    always @(negedge clk) begin
        if (rst) begin
            ack_prev = aer_ack;
        end else begin
            if (aer_ack !== ack_prev) begin
                ack_cnt++;
                if (!((&row_sel_n) && (&col_sel_n))) ack_sel_bad++;
            end
            ack_prev = aer_ack;
            if (evt_valid) begin
                evt_cnt++;
                last_kind = int'(evt_kind);
                last_erow = int'(evt_row);
                last_ecol = int'(evt_col);
            end
            if (range_err) err_cnt++;
        end
    end

    // array model: confirm delivery after a delay, release when strobes drop
    initial begin
        int zr, zc;
        forever begin
            @(negedge clk);
            if (!rst && (!(&row_sel_n) || !(&col_sel_n))) begin
                zr = 0;
                zc = 0;
                for (int i = 0; i < NR; i++) if (!row_sel_n[i]) begin zr++; last_row = i; end
                for (int i = 0; i < NC; i++) if (!col_sel_n[i]) begin zc++; last_col = i; end
                if (zr != 1 || zc != 1) sel_shape_bad++;
                dlv_cnt++;
                repeat (2) @(negedge clk);
                dlv_ack_n = 1'b0;
                while (!((&row_sel_n) && (&col_sel_n))) @(negedge clk);
                dlv_ack_n = 1'b1;
            end
        end
    end

    task automatic wait_ack(input int a0);
        for (int i = 0; i < 300 && ack_cnt == a0; i++) @(negedge clk);
    endtask

    task automatic start_burst(input int id);
        int a0;
        a0 = ack_cnt;
        aer_addr = AW'(id);
        burst_req = 1'b1;
        wait_ack(a0);
        chk(ack_cnt == a0 + 1, "R2 chip word ack", ack_cnt - a0, 1);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_word(input int a, input int hold);
        int a0;
        a0 = ack_cnt;
        aer_addr = AW'(a);
        word_req_n = 1'b0;
        wait_ack(a0);
        repeat (hold) @(negedge clk);
        word_req_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic end_burst();
        burst_req = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_row(input int r);
        int d0, e0, a0;
        d0 = dlv_cnt; e0 = evt_cnt; a0 = ack_cnt;
        send_word(r, 0);
        chk(dlv_cnt == d0 && evt_cnt == e0, "R4 row word silent", dlv_cnt - d0, 0);
        chk(ack_cnt == a0 + 1, "R3 row word ack", ack_cnt - a0, 1);
    endtask

    task automatic deliver_col(input int r, input int c, input int kind);
        int d0, a0;
        d0 = dlv_cnt; a0 = ack_cnt;
        send_word(c, 0);
        chk(dlv_cnt == d0 + 1, "R5 one delivery", dlv_cnt - d0, 1);
        chk(last_row == r, "R5 row strobe", last_row, r);
        chk(last_col == c, "R5 column strobe", last_col, c);
        chk(last_kind == kind, "R7 kind", last_kind, kind);
        chk(last_erow == r && last_ecol == c, "R7 event address", last_erow * 256 + last_ecol, r * 256 + c);
        chk(ack_cnt == a0 + 1, "R6 column ack after delivery", ack_cnt - a0, 1);
    endtask

    task automatic t_reset();
        chk(aer_ack == 1'b0, "R1 ack", int'(aer_ack), 0);
        chk((&row_sel_n) && (&col_sel_n), "R1 selects idle", int'(&row_sel_n), 1);
        chk(!evt_valid && !range_err, "R1 event/error idle", int'(evt_valid | range_err), 0);
    endtask

    task automatic t_local_odd();
        start_burst(0);
        send_row(5);
        deliver_col(5, 3, 3);
        deliver_col(5, 4, 2);
        deliver_col(5, 10, 2);
        end_burst();
    endtask

    task automatic t_local_even();
        start_burst(0);
        send_row(6);
        deliver_col(6, 0, 0);
        deliver_col(6, 1, 1);
        end_burst();
    endtask

    task automatic t_hold_low();
        int a0, d0;
        start_burst(0);
        send_row(1);
        a0 = ack_cnt; d0 = dlv_cnt;
        send_word(7, 20);
        chk(ack_cnt == a0 + 1, "R3 held request one ack", ack_cnt - a0, 1);
        chk(dlv_cnt == d0 + 1, "R3 held request one delivery", dlv_cnt - d0, 1);
        end_burst();
    endtask

    task automatic t_remote();
        int a0, d0, e0, r0;
        start_burst(3);
        a0 = ack_cnt; d0 = dlv_cnt; e0 = evt_cnt; r0 = err_cnt;
        send_word(2, 0);
        send_word(1, 0);
        send_word(40, 0);
        chk(ack_cnt == a0 + 3, "R8 remote words acked", ack_cnt - a0, 3);
        chk(dlv_cnt == d0, "R8 remote no delivery", dlv_cnt - d0, 0);
        chk(evt_cnt == e0 && err_cnt == r0, "R8 remote no event or error", (evt_cnt - e0) + (err_cnt - r0), 0);
        end_burst();
    endtask

    task automatic t_range();
        int a0, d0, r0;
        start_burst(0);
        send_row(2);
        a0 = ack_cnt; d0 = dlv_cnt; r0 = err_cnt;
        send_word(40, 0);
        chk(ack_cnt == a0 + 1, "R9 wide column acked", ack_cnt - a0, 1);
        chk(dlv_cnt == d0, "R9 wide column dropped", dlv_cnt - d0, 0);
        chk(err_cnt == r0 + 1, "R9 wide column error", err_cnt - r0, 1);
        deliver_col(2, 9, 1);
        end_burst();
        start_burst(0);
        r0 = err_cnt;
        send_word(20, 0);
        chk(err_cnt == r0 + 1, "R9 bad row error", err_cnt - r0, 1);
        d0 = dlv_cnt;
        send_word(1, 0);
        chk(dlv_cnt == d0, "R9 bad row columns dropped", dlv_cnt - d0, 0);
        end_burst();
    endtask

    task automatic t_restart();
        start_burst(0);
        send_row(7);
        deliver_col(7, 2, 2);
        end_burst();
        start_burst(0);
        send_row(9);
        deliver_col(9, 5, 3);
        chk(last_row == 9, "R10 new burst takes fresh row", last_row, 9);
        end_burst();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_local_odd();
        t_local_even();
        t_hold_low();
        t_remote();
        t_range();
        t_restart();
        chk(ack_sel_bad == 0, "R6 ack never with strobe low", ack_sel_bad, 0);
        chk(sel_shape_bad == 0, "R5 single row and column strobe", sel_shape_bad, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end
endmodule